// File: doc/BRIEF.md
# Latched Fault Interrupt Controller

This block gathers a set of fault and warning flags (one thermal shutdown, one thermal warning, a group of supply over-current flags and a group of undervoltage flags) into two views. The raw view follows the inputs as they are, registered once. The latched view records a fault only after it has stayed present for a programmable number of reference ticks, and it keeps the record until the host clears it.

An interrupt request is raised whenever a latched bit is set and that bit is enabled. The request is given as a pull-low enable for an external open-drain line. The thermal-shutdown bit always raises the request, whatever its enable holds. The host uses a small register port to read both views, write the enable mask, clear latched bits and force latched bits set.

Source bit order in every register: bit 0 thermal shutdown, bit 1 thermal warning, bits 2 to 1+NUM_OC the over-current flags, then the undervoltage flags above them (bits 5 to 7 with the default parameters).

Top module: `fault_irq_ctrl`

## Requirements
- R1: A read with select 0 returns the fault inputs as sampled at the previous clock edge, in the source bit order.
- R2: A source's latched bit is set only after the source has been high for QUAL_TICKS qualifying clock edges in a row where tick_i is high. With tick_i high every cycle, a fault held for QUAL_TICKS cycles is not latched and one held for QUAL_TICKS+2 cycles is. With tick_i low, no fault is ever latched.
- R3: A source that drops low for even one cycle restarts its qualification count from zero.
- R4: irq_pull_o is 1 one cycle after any latched bit whose effective enable is 1 is set, and 0 when no such bit is set.
- R5: Bit 0 (thermal shutdown) always drives the interrupt; its enable reads back as 1 and writing 0 to it has no effect.
- R6: Bits 1 and above reach the interrupt only when their enable bit (select 3) is 1; after reset the enable mask reads 0x01.
- R7: Writing with select 1 clears every latched bit whose data bit is 1 and leaves the others unchanged. Reads with select 1 or 2 return the latched bits.
- R8: Writing with select 2 sets every latched bit whose data bit is 1.
- R9: If a source is qualified in the same cycle as a clear of its bit, the bit stays set.
- R10: A latched bit is kept after its source goes low; only a clear write or reset removes it.
- R11: A write with select 0 changes neither the latched bits nor the enable mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Reference tick that advances qualification counts |
| tsd_i | input | 1 | Thermal shutdown flag |
| twarn_i | input | 1 | Thermal warning flag |
| ocp_i | input | NUM_OC | Supply over-current flags |
| uv_i | input | NUM_UV | Undervoltage flags |
| reg_sel_i | input | 2 | Register select: 0 raw, 1 latched/clear, 2 latched/set, 3 enable |
| reg_wr_i | input | 1 | Write strobe, one cycle per write |
| reg_wdata_i | input | 2+NUM_OC+NUM_UV | Write data |
| reg_rdata_o | output | 2+NUM_OC+NUM_UV | Read data for the selected register, combinational |
| irq_pull_o | output | 1 | 1 pulls the active-low interrupt line low |

## Verification
The assertions assume the fault flags and the register port are synchronous to the clock, that a write strobe lasts one cycle, and that the select always carries one of the four defined codes. The bench drives every input on the falling edge, holds each write for exactly one cycle and reads the combinational data just before the next rising edge, so the assumed input discipline holds throughout. The qualification boundary is approached from both sides with tick_i high every cycle, and a run with tick_i low shows that the count does not advance on its own.

// File: rtl/fault_irq_pkg.sv
package fault_irq_pkg;

    typedef enum logic [1:0] {
        SEL_RAW   = 2'd0,
        SEL_LATCH = 2'd1,
        SEL_SET   = 2'd2,
        SEL_MASK  = 2'd3
    } reg_sel_e;

    localparam int unsigned TSD_BIT   = 0;
    localparam int unsigned TWARN_BIT = 1;

endpackage

// File: rtl/fault_qualifier.sv
module fault_qualifier #(
    parameter int unsigned QUAL_TICKS = 16
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic tick_i,
    input  logic fault_i,
    output logic raw_o,
    output logic qual_o
);
    localparam int unsigned CNT_W = $clog2(QUAL_TICKS + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(QUAL_TICKS);

    typedef struct packed {
        logic             raw;
        logic [CNT_W-1:0] cnt;
    } qual_st_t;

    qual_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.raw = fault_i;
        if (!st_q.raw) begin
            st_d.cnt = '0;
        end else if (tick_i && (st_q.cnt != CNT_MAX)) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign raw_o  = st_q.raw;
    assign qual_o = st_q.raw && (st_q.cnt == CNT_MAX);

endmodule

// File: rtl/fault_latch_bank.sv
module fault_latch_bank
    import fault_irq_pkg::*;
#(
    parameter int unsigned NSRC = 8
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic [NSRC-1:0] raw_i,
    input  logic [NSRC-1:0] qual_i,
    input  logic [1:0]      reg_sel_i,
    input  logic            reg_wr_i,
    input  logic [NSRC-1:0] reg_wdata_i,
    output logic [NSRC-1:0] reg_rdata_o,
    output logic [NSRC-1:0] latch_o,
    output logic [NSRC-1:0] en_eff_o,
    output logic            irq_pull_o
);
    localparam logic [NSRC-1:0] UNMASKABLE = NSRC'(1) << TSD_BIT;

    typedef struct packed {
        logic [NSRC-1:0] latch;
        logic [NSRC-1:0] en;
        logic            irq;
    } bank_st_t;

    bank_st_t        st_d, st_q;
    logic [NSRC-1:0] clr_mask, set_mask, en_eff;
    reg_sel_e        sel;

    assign sel    = reg_sel_e'(reg_sel_i);
    assign en_eff = st_q.en | UNMASKABLE;

    always_comb begin
        st_d     = st_q;
        clr_mask = '0;
        set_mask = '0;
        if (reg_wr_i) begin
            case (sel)
                SEL_LATCH: clr_mask = reg_wdata_i;
                SEL_SET:   set_mask = reg_wdata_i;
                SEL_MASK:  st_d.en  = reg_wdata_i & ~UNMASKABLE;
                default:   ;
            endcase
        end
        // a qualified source or a set write wins over a clear
        st_d.latch = (st_q.latch & ~clr_mask) | set_mask | qual_i;
        st_d.irq   = |(st_q.latch & en_eff);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (sel)
            SEL_RAW:  reg_rdata_o = raw_i;
            SEL_MASK: reg_rdata_o = en_eff;
            default:  reg_rdata_o = st_q.latch;
        endcase
    end

    assign latch_o    = st_q.latch;
    assign en_eff_o   = en_eff;
    assign irq_pull_o = st_q.irq;

endmodule

// File: rtl/fault_irq_ctrl.sv
module fault_irq_ctrl #(
    parameter int unsigned NUM_OC     = 3,
    parameter int unsigned NUM_UV     = 3,
    parameter int unsigned QUAL_TICKS = 16
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic                       tick_i,
    input  logic                       tsd_i,
    input  logic                       twarn_i,
    input  logic [NUM_OC-1:0]          ocp_i,
    input  logic [NUM_UV-1:0]          uv_i,
    input  logic [1:0]                 reg_sel_i,
    input  logic                       reg_wr_i,
    input  logic [2+NUM_OC+NUM_UV-1:0] reg_wdata_i,
    output logic [2+NUM_OC+NUM_UV-1:0] reg_rdata_o,
    output logic                       irq_pull_o
);
    localparam int unsigned NSRC = 2 + NUM_OC + NUM_UV;

    logic [NSRC-1:0] fault_vec, raw_vec, qual_vec, latch_vec, en_eff_vec;

    assign fault_vec = {uv_i, ocp_i, twarn_i, tsd_i};

    for (genvar g = 0; g < NSRC; g++) begin : g_qual
        fault_qualifier #(
            .QUAL_TICKS(QUAL_TICKS)
        ) i_qual (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .tick_i (tick_i),
            .fault_i(fault_vec[g]),
            .raw_o  (raw_vec[g]),
            .qual_o (qual_vec[g])
        );
    end

    fault_latch_bank #(
        .NSRC(NSRC)
    ) i_bank (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .raw_i      (raw_vec),
        .qual_i     (qual_vec),
        .reg_sel_i  (reg_sel_i),
        .reg_wr_i   (reg_wr_i),
        .reg_wdata_i(reg_wdata_i),
        .reg_rdata_o(reg_rdata_o),
        .latch_o    (latch_vec),
        .en_eff_o   (en_eff_vec),
        .irq_pull_o (irq_pull_o)
    );

endmodule

// File: rtl/fault_irq_ctrl_chk.sv
module fault_irq_ctrl_chk #(
    parameter int unsigned NSRC = 8
) (
    input logic            clk_i,
    input logic            rst_ni,
    input logic [NSRC-1:0] fault_vec,
    input logic [NSRC-1:0] raw_vec,
    input logic [NSRC-1:0] qual_vec,
    input logic [NSRC-1:0] latch_vec,
    input logic [NSRC-1:0] en_eff_vec,
    input logic [1:0]      reg_sel_i,
    input logic            reg_wr_i,
    input logic            irq_pull_o
);
    AST_RAW_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> raw_vec == $past(fault_vec)); // R1

    AST_NO_SET_WITHOUT_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!reg_wr_i && (qual_vec == '0)) |=> $stable(latch_vec)); // R2

    AST_IRQ_FROM_ENABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((latch_vec & en_eff_vec) == '0) |=> !irq_pull_o); // R4

    AST_TSD_UNMASKABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        latch_vec[0] |=> irq_pull_o); // R5

    AST_LATCH_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(reg_wr_i && (reg_sel_i == 2'd1))
        |=> ((latch_vec & $past(latch_vec)) == $past(latch_vec))); // R10

    AST_QUAL_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (qual_vec != '0) |=> ((latch_vec & $past(qual_vec)) == $past(qual_vec))); // R9

endmodule

bind fault_irq_ctrl fault_irq_ctrl_chk #(
    .NSRC(NSRC)
) i_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fault_vec (fault_vec),
    .raw_vec   (raw_vec),
    .qual_vec  (qual_vec),
    .latch_vec (latch_vec),
    .en_eff_vec(en_eff_vec),
    .reg_sel_i (reg_sel_i),
    .reg_wr_i  (reg_wr_i),
    .irq_pull_o(irq_pull_o)
);

// File: tb/test_fault_irq_ctrl.sv
module test_fault_irq_ctrl;
    localparam int unsigned Q = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b1;
    logic [7:0] fvec = '0;
    logic [1:0] sel = '0;
    logic       wr = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       irq;
    int         n_chk = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    fault_irq_ctrl i_fault_irq_ctrl (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .tick_i     (tick),
        .tsd_i      (fvec[0]),
        .twarn_i    (fvec[1]),
        .ocp_i      (fvec[4:2]),
        .uv_i       (fvec[7:5]),
        .reg_sel_i  (sel),
        .reg_wr_i   (wr),
        .reg_wdata_i(wdata),
        .reg_rdata_o(rdata),
        .irq_pull_o (irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic [1:0] s, input logic [7:0] d);
        @(negedge clk);
        sel = s; wr = 1'b1; wdata = d;
        @(negedge clk);
        wr = 1'b0; wdata = '0;
    endtask

    task automatic read_reg(input logic [1:0] s, output logic [7:0] v);
        @(negedge clk);
        sel = s;
        #1 v = rdata;
    endtask

    task automatic hold_fault(input logic [7:0] f, input int cycles);
        @(negedge clk);
        fvec = f;
        repeat (cycles) @(negedge clk);
        fvec = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [7:0] v;
        read_reg(2'd1, v); check("R7 reset latch", v, 8'h00);
        read_reg(2'd3, v); check("R6 reset enable", v, 8'h01);
        check("R4 reset irq", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_raw;
        logic [7:0] v;
        @(negedge clk);
        fvec = 8'hA5;
        sel = 2'd0;
        @(negedge clk);
        #1 v = rdata;
        check("R1 raw view", v, 8'hA5);
        fvec = 8'h00;
        idle(2);
        write_reg(2'd0, 8'hFF);
        read_reg(2'd1, v); check("R11 latch after select-0 write", v, 8'h00);
        read_reg(2'd3, v); check("R11 enable after select-0 write", v, 8'h01);
    endtask

    task automatic t_qualify;
        logic [7:0] v;
        hold_fault(8'h02, Q);
        idle(4);
        read_reg(2'd1, v); check("R2 held QUAL_TICKS not latched", v, 8'h00);
        hold_fault(8'h02, Q + 2);
        idle(3);
        read_reg(2'd1, v); check("R2 held QUAL_TICKS+2 latched", v, 8'h02);
        check("R6 masked warning no irq", {7'd0, irq}, 8'h00);
        write_reg(2'd3, 8'h02);
        idle(2);
        check("R4 enabled warning irq", {7'd0, irq}, 8'h01);
        write_reg(2'd1, 8'h02);
        idle(2);
        read_reg(2'd1, v); check("R7 clear latch", v, 8'h00);
        check("R4 irq released", {7'd0, irq}, 8'h00);
        write_reg(2'd3, 8'h00);
    endtask

    task automatic t_restart;
        logic [7:0] v;
        hold_fault(8'h04, Q - 2);
        hold_fault(8'h04, Q - 2);
        idle(4);
        read_reg(2'd1, v); check("R3 dropout restarts count", v, 8'h00);
    endtask

    task automatic t_tsd;
        logic [7:0] v;
        write_reg(2'd3, 8'h00);
        read_reg(2'd3, v); check("R5 tsd enable reads 1", v, 8'h01);
        hold_fault(8'h01, Q + 2);
        idle(3);
        read_reg(2'd1, v); check("R5 tsd latched", v, 8'h01);
        check("R5 tsd irq unmaskable", {7'd0, irq}, 8'h01);
        write_reg(2'd1, 8'h01);
        idle(2);
        check("R4 irq low after tsd clear", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_set;
        logic [7:0] v;
        write_reg(2'd2, 8'h90);
        read_reg(2'd2, v); check("R8 set write", v, 8'h90);
        write_reg(2'd3, 8'h80);
        idle(2);
        check("R6 enabled forced bit irq", {7'd0, irq}, 8'h01);
        write_reg(2'd1, 8'h10);
        read_reg(2'd1, v); check("R7 partial clear", v, 8'h80);
        write_reg(2'd1, 8'h80);
        write_reg(2'd3, 8'h00);
        idle(2);
        read_reg(2'd1, v); check("R7 full clear", v, 8'h00);
    endtask

    task automatic t_setwins;
        logic [7:0] v;
        @(negedge clk);
        fvec = 8'h08;
        idle(Q + 4);
        write_reg(2'd1, 8'h08);
        read_reg(2'd1, v); check("R9 qualified beats clear", v, 8'h08);
        fvec = 8'h00;
        idle(2);
        write_reg(2'd1, 8'h08);
        read_reg(2'd1, v); check("R7 clear after release", v, 8'h00);
    endtask

    task automatic t_retain;
        logic [7:0] v;
        hold_fault(8'h20, Q + 2);
        idle(50);
        read_reg(2'd1, v); check("R10 latch retained", v, 8'h20);
        write_reg(2'd1, 8'h20);
    endtask

    task automatic t_tick;
        logic [7:0] v;
        @(negedge clk);
        tick = 1'b0;
        hold_fault(8'h40, 3 * Q);
        idle(3);
        read_reg(2'd1, v); check("R2 no tick no latch", v, 8'h00);
        tick = 1'b1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);
        t_reset();
        t_raw();
        t_qualify();
        t_restart();
        t_tsd();
        t_set();
        t_setwins();
        t_retain();
        t_tick();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule